// File: doc/BRIEF.md
# Time-Multiplexed Dual Hex Display Driver

This block shows two 4-bit switch values as two hexadecimal digits on a two-digit common-anode seven-segment display. Both digits share one hex-to-segment decoder. A two-state selector decides which value goes into the decoder and which digit has its common enable asserted. A free-running counter sets how fast the digits alternate. With the default parameters and a 48 MHz clock, each digit is lit for 2^19 cycles, which gives about 91 digit swaps per second. That rate is fast enough that both digits appear steadily lit.

The digit enables drive high-side PNP switches, so they are active low. The segment lines are active low as well. The selector state, the segment pattern and the enable are all updated on the same clock edge, so a newly enabled digit never shows the other digit's pattern. Separately from the display, a combinational adder drives the 5-bit unsigned sum of the two inputs onto five LEDs.

The inputs are static switch levels. They have no handshake, and there is no back-pressure at any port.

Top module: `dual_hex_mux_driver`

## Requirements
- R1: `sum_led` equals `val_a + val_b` as a 5-bit unsigned value and follows input changes without waiting for a clock edge.
- R2: `dig_en_n` never has both bits low in the same cycle.
- R3: While `rst` is sampled high, the block clears its counter and selects digit A. After that edge, `dig_en_n` is 2'b11 and `seg_n` is 7'h7F (all segments off).
- R4: From the first edge after `rst` falls, exactly one enable bit is low. Digit A is selected first, shown as `dig_en_n` = 2'b10 (bit 0 enables digit A, bit 1 enables digit B).
- R5: Let k count the clock edges since the last reset edge, with k = 1 at the first edge after release. After edge k, the selected digit is B when bit SEL_BIT of k is 1 and A otherwise. The enable changes only at those boundaries.
- R6: After each edge, `seg_n` is the decoded pattern of the input sampled at that edge for the digit now enabled: `val_a` when bit 0 is low, `val_b` when bit 1 is low.
- R7: Segment bit order is {g,f,e,d,c,b,a}, and a 0 in a bit lights that segment. The 16 codes map to 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex). No code produces the all-off pattern.
- R8: The enable and the segment pattern change on the same edge, so the pattern seen alongside a newly enabled digit is always that digit's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz for the default rate) |
| rst | input | 1 | Synchronous active-high reset |
| val_a | input | 4 | Switch value for digit A |
| val_b | input | 4 | Switch value for digit B |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dig_en_n | output | 2 | Active-low digit enables, bit 0 for A and bit 1 for B |
| sum_led | output | 5 | Unsigned sum of the two values |

## Verification
The bench builds the block with SEL_BIT = 3 and CNT_W = 5, so each digit is lit for 8 cycles instead of about half a million. At that setting, several full swap periods, a mid-scan reset and input changes on both sides of a swap boundary all fit in a short run. The adder does not depend on these parameters, so all 256 input pairs are checked for the sum.

// File: rtl/dhx_pkg.sv
package dhx_pkg;
  localparam int NIBBLE_W = 4;
  localparam int SEG_W    = 7;
  localparam int DIGITS   = 2;

  typedef logic [NIBBLE_W-1:0] nibble_t;
  typedef logic [SEG_W-1:0]    seg_t;

  typedef enum logic {DIG_A = 1'b0, DIG_B = 1'b1} dig_sel_e;

  localparam seg_t SEG_BLANK = '1;
endpackage

// File: rtl/dhx_rate_div.sv
module dhx_rate_div #(
  parameter int CNT_W   = 20,
  parameter int SEL_BIT = 19
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int LOW_W = SEL_BIT;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // The select bit is about to toggle whenever every bit below it is set.
  assign tick = &cnt_q[LOW_W-1:0];

  initial begin
    assert (SEL_BIT >= 1 && SEL_BIT < CNT_W)
      else $error("SEL_BIT must lie inside the counter");
  end
endmodule

// File: rtl/dhx_seg_decode.sv
module dhx_seg_decode
  import dhx_pkg::*;
(
  input  nibble_t code,
  output seg_t    seg_n
);
  always_comb begin
    unique case (code)
      4'h0: seg_n = 7'b1000000;
      4'h1: seg_n = 7'b1111001;
      4'h2: seg_n = 7'b0100100;
      4'h3: seg_n = 7'b0110000;
      4'h4: seg_n = 7'b0011001;
      4'h5: seg_n = 7'b0010010;
      4'h6: seg_n = 7'b0000010;
      4'h7: seg_n = 7'b1111000;
      4'h8: seg_n = 7'b0000000;
      4'h9: seg_n = 7'b0010000;
      4'hA: seg_n = 7'b0001000;
      4'hB: seg_n = 7'b0000011;
      4'hC: seg_n = 7'b1000110;
      4'hD: seg_n = 7'b0100001;
      4'hE: seg_n = 7'b0000110;
      default: seg_n = 7'b0001110;
    endcase
  end

  always_comb begin
    if (!$isunknown(code))
      assert_seg_nonblank_R7: assert (seg_n != SEG_BLANK);
  end
endmodule

// File: rtl/dhx_sum.sv
module dhx_sum #(
  parameter int IN_W = 4
) (
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  output logic [IN_W:0]   s
);
  assign s = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/dual_hex_mux_driver.sv
module dual_hex_mux_driver
  import dhx_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int SEL_BIT = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] val_a,
  input  logic [3:0] val_b,
  output logic [6:0] seg_n,
  output logic [1:0] dig_en_n,
  output logic [4:0] sum_led
);
  logic     tick;
  dig_sel_e sel_q, sel_d;
  nibble_t  dec_in;
  seg_t     dec_out;
  seg_t     seg_q;
  logic [DIGITS-1:0] en_q, en_d;

  dhx_rate_div #(.CNT_W(CNT_W), .SEL_BIT(SEL_BIT)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  always_comb begin
    sel_d = sel_q;
    if (tick) sel_d = (sel_q == DIG_A) ? DIG_B : DIG_A;
  end

  // Decode the next state's value so that pattern and enable move together.
  assign dec_in = (sel_d == DIG_B) ? val_b : val_a;

  dhx_seg_decode u_dec (
    .code (dec_in),
    .seg_n(dec_out)
  );

  always_comb begin
    en_d = '1;
    en_d[sel_d] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= DIG_A;
      en_q  <= '1;
      seg_q <= SEG_BLANK;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
      seg_q <= dec_out;
    end
  end

  assign seg_n    = seg_q;
  assign dig_en_n = en_q;

  dhx_sum #(.IN_W(NIBBLE_W)) u_sum (
    .a(val_a),
    .b(val_b),
    .s(sum_led)
  );

  assert_never_both_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_en_n));

  assert_one_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(~dig_en_n) == 1));

  assert_swap_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && (dig_en_n != $past(dig_en_n)))
      |-> $past(tick));
endmodule

// File: tb/tb_dual_hex_mux_driver.sv
module tb_dual_hex_mux_driver;
  localparam int SB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] val_a = '0, val_b = '0;
  logic [6:0] seg_n;
  logic [1:0] dig_en_n;
  logic [4:0] sum_led;

  int tests = 0, fails = 0;
  int k = 0;
  bit done = 1'b0;

  dual_hex_mux_driver #(.CNT_W(5), .SEL_BIT(SB)) dut (
    .clk(clk), .rst(rst), .val_a(val_a), .val_b(val_b),
    .seg_n(seg_n), .dig_en_n(dig_en_n), .sum_led(sum_led)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  function automatic logic [6:0] ref_seg(input logic [3:0] c);
    case (c)
      4'h0: return 7'h40; 4'h1: return 7'h79; 4'h2: return 7'h24; 4'h3: return 7'h30;
      4'h4: return 7'h19; 4'h5: return 7'h12; 4'h6: return 7'h02; 4'h7: return 7'h78;
      4'h8: return 7'h00; 4'h9: return 7'h10; 4'hA: return 7'h08; 4'hB: return 7'h03;
      4'hC: return 7'h46; 4'hD: return 7'h21; 4'hE: return 7'h06; default: return 7'h0E;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (k=%0d)", req, act, exp, k);
    end
  endtask

  // Check enable and pattern at the current negedge from the edge count.
  task automatic check_display(input string req);
    logic digb;
    digb = k[SB];
    check({req, " enable"}, dig_en_n, digb ? 2'b01 : 2'b10);
    check({req, " pattern"}, seg_n, ref_seg(digb ? val_b : val_a));
    check("R2 both-low", (dig_en_n == 2'b00), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R3 enables off", dig_en_n, 2'b11);
    check("R3 blank segments", seg_n, 7'h7F);
    rst = 1'b0;
    @(negedge clk);
    check("R4 first digit A", dig_en_n, 2'b10);
  endtask

  task automatic t_sum_all();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        val_a = a[3:0]; val_b = b[3:0];
        #1;
        check("R1 sum", sum_led, a + b);
      end
    end
  endtask

  task automatic t_scan(input logic [3:0] a, input logic [3:0] b, input int n);
    val_a = a; val_b = b;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      check_display("R5/R6/R8 scan");
      @(negedge clk);
    end
  endtask

  task automatic t_decode_table();
    for (int c = 0; c < 16; c++) begin
      val_a = c[3:0]; val_b = 4'(15 - c);
      @(negedge clk);
      check_display("R7 decode");
    end
  endtask

  task automatic t_boundary_change();
    // Change inputs right before a swap and confirm the new digit shows new data.
    while (((k + 1) % (1 << SB)) != 0) @(negedge clk);
    val_a = 4'h3; val_b = 4'hC;
    @(negedge clk);
    check_display("R8 boundary");
    @(negedge clk);
    check_display("R6 after boundary");
  endtask

  initial begin
    t_reset();
    t_sum_all();
    t_scan(4'h1, 4'hE, 40);
    t_scan(4'hA, 4'h5, 20);
    t_decode_table();
    t_decode_table();
    t_boundary_change();
    t_boundary_change();
    repeat (5) @(negedge clk);
    t_reset();
    t_scan(4'h7, 4'h8, 24);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule